// File: doc/BRIEF.md
# DRAM Refresh Request Generator

This block issues periodic DRAM refresh requests for a small embedded processor bus. A programmable down-counter sets the time between refreshes. When the interval runs out, the block raises a memory-read request toward the bus interface unit. With that request it supplies a refresh address whose low bits are a row counter. The request stays up until the bus interface acknowledges it. The row counter then advances and the interval starts again.

Refresh runs only while the enhanced-mode enable is high and the programmed interval is non-zero. The block also compares the refresh address against one programmed chip-select window. It raises a select output for the duration of a pending refresh whose address falls inside that window, so the memory that decodes that range is selected during the refresh read. The counter runs on the processor clock, which is the divided clock in power-save mode, so the refresh period scales with the divide factor.

Top module: `dram_refresh_gen`

## Requirements
- R1: After reset, `rfsh_req_o` and `cs_sel_o` are 0 and the row field of `rfsh_addr_o` (bits 8:0) is 0.
- R2: While `enh_en_i` is sampled low, no request is raised. Dropping `enh_en_i` while a request is pending removes it at the next edge and leaves the row unchanged.
- R3: With interval N (1 to 511), `rfsh_req_o` rises at the (N+1)-th rising edge counted from the first edge that samples the block active. It also rises at the (N+1)-th edge after the edge that accepts an acknowledge.
- R4: An interval value of 0 disables refresh: no request is raised even with `enh_en_i` high.
- R5: A raised request stays high until an edge samples `ack_i` high. An `ack_i` pulse while no request is pending is ignored and leaves the row unchanged.
- R6: Each accepted acknowledge increments the 9-bit row by one, wrapping from 511 to 0. `rfsh_addr_o` equals {`page_i`, row}, with the row in bits 8:0.
- R7: `cs_sel_o` is 1 exactly when `rfsh_req_o` is 1 and `cs_base_i` <= `rfsh_addr_o` < `cs_base_i` + `cs_size_i`. The sum is taken without wrap, and a size of 0 never selects.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Processor clock (divided in power-save mode) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| enh_en_i | input | 1 | Enhanced-mode enable; refresh runs only while high |
| interval_i | input | 9 | Refresh interval in clocks; 0 disables |
| page_i | input | 11 | Fixed upper bits of the refresh address |
| ack_i | input | 1 | Bus interface acknowledge of the refresh read |
| cs_base_i | input | 20 | Chip-select window start address |
| cs_size_i | input | 20 | Chip-select window length in bytes |
| rfsh_req_o | output | 1 | Memory-read refresh request |
| rfsh_addr_o | output | 20 | Refresh address |
| cs_sel_o | output | 1 | Chip select asserted for the pending refresh |

## Verification
A wrong interval count shows as a request edge that comes one or more clocks early or late, so it is visible on the first refresh after activation or acknowledge. A row counter that skips, sticks or wraps wrongly corrupts `rfsh_addr_o` at the next acknowledge and stays wrong on every later refresh. A window comparator with an off-by-one at either bound produces a wrong `cs_sel_o` only on the refresh whose row lands on that boundary. For that reason the bench walks the row through all 512 values across several windows.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;
  parameter int unsigned ADDR_W = 20;
  parameter int unsigned ROW_W  = 9;
  parameter int unsigned CNT_W  = 9;
  localparam int unsigned PAGE_W = ADDR_W - ROW_W;
endpackage

// File: rtl/rfsh_timer.sv
module rfsh_timer #(
  parameter int unsigned CNT_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] interval_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;

  // cnt_q == 0 means "load on next edge"
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (!run_i)                   cnt_q <= '0;
    else if (cnt_q == '0)              cnt_q <= interval_i;
    else if (cnt_q == CNT_W'(1))       cnt_q <= '0;
    else                               cnt_q <= cnt_q - CNT_W'(1);
  end

  assign expire_o = run_i && (cnt_q == CNT_W'(1));

  p_idle_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
endmodule

// File: rtl/rfsh_row.sv
module rfsh_row #(
  parameter int unsigned ROW_W = 9
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_o <= '0;
    else if (step_i) row_o <= row_o + ROW_W'(1);
  end

  p_row_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(row_o));
endmodule

// File: rtl/rfsh_window.sv
module rfsh_window #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] size_i,
  output logic              hit_o
);
  logic [ADDR_W:0] limit;

  // one extra bit so a window ending at the top of memory does not wrap
  assign limit = {1'b0, base_i} + {1'b0, size_i};
  assign hit_o = (addr_i >= base_i) && ({1'b0, addr_i} < limit);

  p_size0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_i == '0) |-> !hit_o);
endmodule

// File: rtl/dram_refresh_gen.sv
module dram_refresh_gen
  import rfsh_pkg::*;
#(
  parameter int unsigned P_ADDR_W = ADDR_W,
  parameter int unsigned P_ROW_W  = ROW_W,
  parameter int unsigned P_CNT_W  = CNT_W,
  localparam int unsigned P_PAGE_W = P_ADDR_W - P_ROW_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                enh_en_i,
  input  logic [P_CNT_W-1:0]  interval_i,
  input  logic [P_PAGE_W-1:0] page_i,
  input  logic                ack_i,
  input  logic [P_ADDR_W-1:0] cs_base_i,
  input  logic [P_ADDR_W-1:0] cs_size_i,
  output logic                rfsh_req_o,
  output logic [P_ADDR_W-1:0] rfsh_addr_o,
  output logic                cs_sel_o
);
  logic active, run, expire, step, hit, req_q;
  logic [P_ROW_W-1:0] row;

  assign active = enh_en_i && (interval_i != '0);
  assign run    = active && !req_q;
  assign step   = active && req_q && ack_i;

  rfsh_timer #(.CNT_W(P_CNT_W)) u_timer (
    .clk_i, .rst_ni, .run_i(run), .interval_i, .expire_o(expire)
  );

  rfsh_row #(.ROW_W(P_ROW_W)) u_row (
    .clk_i, .rst_ni, .step_i(step), .row_o(row)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      req_q <= 1'b0;
    else if (!active) req_q <= 1'b0;
    else if (expire)  req_q <= 1'b1;
    else if (step)    req_q <= 1'b0;
  end

  assign rfsh_addr_o = {page_i, row};

  rfsh_window #(.ADDR_W(P_ADDR_W)) u_win (
    .clk_i, .rst_ni, .addr_i(rfsh_addr_o), .base_i(cs_base_i),
    .size_i(cs_size_i), .hit_o(hit)
  );

  assign rfsh_req_o = req_q;
  assign cs_sel_o   = req_q && hit;

  p_off_no_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !enh_en_i |=> !rfsh_req_o);
  p_zero_interval_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (interval_i == '0) |=> !rfsh_req_o);
  p_hold_until_ack_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_req_o && !ack_i && active) |=> rfsh_req_o);
  p_row_step_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rfsh_req_o && ack_i && active) |=> (row == $past(row) + P_ROW_W'(1)));
  p_expire_single_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> !expire);
  p_sel_needs_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_sel_o |-> rfsh_req_o);
endmodule

// File: tb/dram_refresh_gen_test.sv
module dram_refresh_gen_test;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic enh_en_i = 1'b0;
  logic [8:0] interval_i = '0;
  logic [10:0] page_i = '0;
  logic ack_i = 1'b0;
  logic [19:0] cs_base_i = '0;
  logic [19:0] cs_size_i = '0;
  logic rfsh_req_o, cs_sel_o;
  logic [19:0] rfsh_addr_o;

  int total = 0;
  int bad = 0;
  int exp_row = 0;
  int wd = 0;
  bit done = 0;

  dram_refresh_gen uut (.*);

  always #4 clk_i = ~clk_i;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic bit in_win(input int addr);
    longint b, s;
    b = cs_base_i;
    s = cs_size_i;
    return (longint'(addr) >= b) && (longint'(addr) < b + s);
  endfunction

  // counts edges until request; expects n+1
  task automatic wait_req(input int n, input string tag);
    int lat = 0;
    for (int k = 1; k <= n + 4; k++) begin
      @(negedge clk_i);
      if (rfsh_req_o) begin lat = k; break; end
    end
    check(lat == n + 1, tag, lat, n + 1);
  endtask

  task automatic do_ack(input string tag);
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    exp_row = (exp_row + 1) % 512;
    check(!rfsh_req_o, tag, rfsh_req_o, 0);
  endtask

  task automatic check_row(input string tag);
    int ea = (int'(page_i) << 9) | exp_row;
    check(rfsh_addr_o == 20'(ea), tag, rfsh_addr_o, ea);
  endtask

  task automatic check_sel(input string tag);
    int ea = (int'(page_i) << 9) | exp_row;
    bit e = rfsh_req_o && in_win(ea);
    check(cs_sel_o == e, tag, cs_sel_o, e);
  endtask

  initial begin
    while (!done) begin
      @(posedge clk_i);
      wd++;
      if (wd > 150000) begin
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=0", wd);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    int hits;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    check(!rfsh_req_o, "R1 req", rfsh_req_o, 0);
    check(!cs_sel_o, "R1 sel", cs_sel_o, 0);
    check(rfsh_addr_o[8:0] == 0, "R1 row", rfsh_addr_o[8:0], 0);
    rst_ni = 1'b1;
    page_i = 11'h2A5;

    // R2 disabled: no request
    interval_i = 9'd3;
    hits = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk_i); hits += rfsh_req_o; end
    check(hits == 0, "R2 off", hits, 0);

    // R4 zero interval
    interval_i = 9'd0;
    enh_en_i = 1'b1;
    hits = 0;
    for (int k = 0; k < 30; k++) begin @(negedge clk_i); hits += rfsh_req_o; end
    check(hits == 0, "R4 zero", hits, 0);
    enh_en_i = 1'b0;
    @(negedge clk_i);

    // R3 latency sweep, R5 hold, R6 row step
    for (int n = 1; n <= 7; n++) begin
      interval_i = 9'(n);
      enh_en_i = 1'b1;
      wait_req(n, "R3 start");
      repeat (3) @(negedge clk_i);
      check(rfsh_req_o, "R5 hold", rfsh_req_o, 1);
      check_row("R6 before ack");
      do_ack("R5 ack clears");
      check_row("R6 step");
      wait_req(n, "R3 after ack");
      do_ack("R5 ack clears");
      enh_en_i = 1'b0;
      @(negedge clk_i);
    end

    // R5 ack with no pending request is ignored
    ack_i = 1'b1;
    @(negedge clk_i);
    ack_i = 1'b0;
    @(negedge clk_i);
    check_row("R5 stray ack");

    // R2 withdraw pending request
    interval_i = 9'd2;
    enh_en_i = 1'b1;
    wait_req(2, "R3 pre-withdraw");
    enh_en_i = 1'b0;
    @(negedge clk_i);
    check(!rfsh_req_o, "R2 withdraw", rfsh_req_o, 1'b0);
    check_row("R2 row kept");

    // R6/R7 full row sweeps over several windows
    interval_i = 9'd1;
    for (int w = 0; w < 4; w++) begin
      case (w)
        0: begin cs_base_i = {page_i, 9'd100}; cs_size_i = 20'd50; end
        1: begin cs_base_i = {page_i, 9'd0} - 20'd10; cs_size_i = 20'd30; end
        2: begin cs_base_i = {page_i, 9'd200}; cs_size_i = 20'd0; end
        default: begin cs_base_i = {page_i, 9'd511}; cs_size_i = 20'd1; end
      endcase
      enh_en_i = 1'b1;
      for (int r = 0; r < 520; r++) begin
        wait_req(1, "R3 sweep");
        check_row("R6 sweep");
        check_sel("R7 window");
        do_ack("R5 sweep ack");
        check(!cs_sel_o, "R7 idle sel", cs_sel_o, 0);
      end
      enh_en_i = 1'b0;
      @(negedge clk_i);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule